// File: doc/BRIEF.md
# Lockable Translation Cache with Round-Robin Replacement

This block is a small fully associative cache of address translations for a device-side memory management unit. Every slot holds a virtual page tag, a page size, a valid flag, a preserve flag, a physical page and a few attribute bits. A lookup port takes a 32-bit device address and returns, in the same cycle, whether it hit, the translated physical address and the attributes of the matching slot.

Software manages the contents through a one-cycle command port. It can write a pair of lock indices, load a slot, invalidate every slot that covers an address, or invalidate everything. The lower `lock_base` slots are protected from replacement. An ordinary load goes to the slot named by `lock_victim`, and that pointer then cycles only through the unprotected slots. A preserved load places the entry at the lock base and moves the base up by one. The slot at the victim index is always visible on the readback outputs, so entry n is read by setting the victim index to n.

Top module: `xlat_cache`

## Requirements
- R1: After reset, `lock_base` and `lock_victim` are 0, no slot is valid and `lk_hit` is 0.
- R2: A load with `op_keep`=0 (op code 2) writes the slot at `lock_victim`. The victim index then goes up by one, and when it reaches N_ENTRIES it returns to the current `lock_base`, not to 0.
- R3: A load with `op_keep`=1 writes the slot at `lock_base`. Afterwards both `lock_base` and `lock_victim` equal the old base plus one.
- R4: A preserved load while `lock_base` equals N_ENTRIES, or an ordinary load while `lock_victim` equals N_ENTRIES, writes nothing and changes neither index. `op_busy` is high for exactly the cycle after the rejected command.
- R5: The set-lock command (op code 1) loads `op_base` and `op_victim` into the two indices. A value above N_ENTRIES is stored as N_ENTRIES.
- R6: The `rd_*` outputs show the slot at `lock_victim`: its valid and preserve flags, its size, its virtual and physical base addresses and its attributes. When `lock_victim` equals N_ENTRIES, `rd_valid` is 0.
- R7: Flush-by-address (op code 3) clears valid on every slot whose range, from its aligned virtual base to the base plus its page size, contains `op_vpage`. Other slots are unchanged.
- R8: Flush-all (op code 4) clears every valid flag and sets both indices to 0.
- R9: The size codes are 0 for 16 MB, 1 for 1 MB, 2 for 64 KB and 3 for 4 KB. A lookup compares only the page bits above that size's offset. The physical address takes the stored physical base above the offset and the lookup address below it.
- R10: When several valid slots match a lookup, the slot with the lowest index supplies the result.
- R11: `lk_hit`, `lk_paddr` and `lk_attr` follow `lk_addr` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 3 | 0 none, 1 set lock, 2 load, 3 flush by address, 4 flush all |
| op_vpage | input | 20 | Virtual page (address bits 31:12) for load or flush |
| op_size | input | 2 | Page size code for load |
| op_keep | input | 1 | Load as a preserved entry |
| op_ppage | input | 20 | Physical page (address bits 31:12) for load |
| op_attr | input | ATTR_W | Attributes for load |
| op_base | input | CNT_W | New lock base for set lock |
| op_victim | input | CNT_W | New victim index for set lock |
| lk_addr | input | 32 | Lookup device address |
| lk_hit | output | 1 | Lookup matched a valid slot |
| lk_paddr | output | 32 | Translated address (0 on miss) |
| lk_attr | output | ATTR_W | Attributes of the matching slot (0 on miss) |
| lock_base | output | CNT_W | Number of protected low slots |
| lock_victim | output | CNT_W | Slot used by the next ordinary load |
| op_busy | output | 1 | Pulse for a rejected load |
| rd_valid | output | 1 | Readback: valid flag |
| rd_keep | output | 1 | Readback: preserve flag |
| rd_size | output | 2 | Readback: size code |
| rd_vaddr | output | 32 | Readback: virtual base |
| rd_paddr | output | 32 | Readback: physical base |
| rd_attr | output | ATTR_W | Readback: attributes |

## Verification
Lookup results are combinational, so the bench changes `lk_addr` and samples the results one nanosecond later, with no clock edge in between. A command presented before a rising edge shows its effect on the indices, the readback outputs, `op_busy` and later lookups right after that same edge. The bench reference model is updated on that edge, and the comparison runs three nanoseconds after it, before new inputs arrive on the falling edge. Directed checks read the outputs on the falling edge that follows each command.

// File: rtl/xc_pkg.sv
package xc_pkg;
  localparam int PG_W = 20;

  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_SETLOCK   = 3'd1,
    OP_LOAD      = 3'd2,
    OP_FLUSH_VA  = 3'd3,
    OP_FLUSH_ALL = 3'd4
  } xc_op_e;

  // page-number bits that take part in a compare, per size code
  function automatic logic [PG_W-1:0] page_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    page_mask = 20'hFF000;  // 16 MB
      2'd1:    page_mask = 20'hFFF00;  // 1 MB
      2'd2:    page_mask = 20'hFFFF0;  // 64 KB
      default: page_mask = 20'hFFFFF;  // 4 KB
    endcase
  endfunction
endpackage

// File: rtl/xc_entry.sv
module xc_entry
  import xc_pkg::*;
#(
  parameter int ATTR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PG_W-1:0]   wr_vpage,
  input  logic [PG_W-1:0]   wr_ppage,
  input  logic [1:0]        wr_size,
  input  logic              wr_keep,
  input  logic [ATTR_W-1:0] wr_attr,
  input  logic              inv_all,
  input  logic              fl_en,
  input  logic [PG_W-1:0]   fl_page,
  input  logic [PG_W-1:0]   lk_page,
  output logic              valid_q,
  output logic              keep_q,
  output logic [1:0]        size_q,
  output logic [PG_W-1:0]   vpage_q,
  output logic [PG_W-1:0]   ppage_q,
  output logic [ATTR_W-1:0] attr_q,
  output logic              lk_match
);
  logic [PG_W-1:0] cur_mask, wr_mask;
  logic            fl_match;

  assign wr_mask  = page_mask(wr_size);
  assign cur_mask = page_mask(size_q);
  assign lk_match = valid_q && (((lk_page ^ vpage_q) & cur_mask) == '0);
  assign fl_match = valid_q && (((fl_page ^ vpage_q) & cur_mask) == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      keep_q  <= 1'b0;
      size_q  <= '0;
      vpage_q <= '0;
      ppage_q <= '0;
      attr_q  <= '0;
    end else if (inv_all) begin
      valid_q <= 1'b0;
    end else if (wr_en) begin
      valid_q <= 1'b1;
      keep_q  <= wr_keep;
      size_q  <= wr_size;
      vpage_q <= wr_vpage & wr_mask;
      ppage_q <= wr_ppage & wr_mask;
      attr_q  <= wr_attr;
    end else if (fl_en && fl_match) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/xc_lock_ctrl.sv
module xc_lock_ctrl #(
  parameter int N     = 8,
  parameter int CNT_W = 4,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             do_set,
  input  logic             do_load,
  input  logic             do_flush_all,
  input  logic             ld_keep,
  input  logic [CNT_W-1:0] set_base,
  input  logic [CNT_W-1:0] set_victim,
  output logic [CNT_W-1:0] base_q,
  output logic [CNT_W-1:0] victim_q,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             busy_q
);
  localparam logic [CNT_W-1:0] N_C = CNT_W'(N);

  logic             load_ok;
  logic [CNT_W-1:0] base_inc, vic_inc;

  assign load_ok  = do_load && (ld_keep ? (base_q != N_C) : (victim_q < N_C));
  assign wr_en    = load_ok;
  assign wr_idx   = ld_keep ? base_q[IDX_W-1:0] : victim_q[IDX_W-1:0];
  assign base_inc = base_q + 1'b1;
  assign vic_inc  = victim_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      victim_q <= '0;
      busy_q   <= 1'b0;
    end else begin
      busy_q <= do_load && !load_ok;
      if (do_flush_all) begin
        base_q   <= '0;
        victim_q <= '0;
      end else if (do_set) begin
        base_q   <= (set_base > N_C) ? N_C : set_base;
        victim_q <= (set_victim > N_C) ? N_C : set_victim;
      end else if (load_ok) begin
        if (ld_keep) begin
          base_q   <= base_inc;
          victim_q <= base_inc;   // wrap target equals the new base
        end else begin
          victim_q <= (vic_inc == N_C) ? base_q : vic_inc;
        end
      end
    end
  end
endmodule

// File: rtl/xc_prio.sv
module xc_prio #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xc_pkg::*;
#(
  parameter int  N_ENTRIES = 8,
  parameter int  ATTR_W    = 4,
  localparam int CNT_W     = $clog2(N_ENTRIES + 1),
  localparam int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_code,
  input  logic [19:0]       op_vpage,
  input  logic [1:0]        op_size,
  input  logic              op_keep,
  input  logic [19:0]       op_ppage,
  input  logic [ATTR_W-1:0] op_attr,
  input  logic [CNT_W-1:0]  op_base,
  input  logic [CNT_W-1:0]  op_victim,
  input  logic [31:0]       lk_addr,
  output logic              lk_hit,
  output logic [31:0]       lk_paddr,
  output logic [ATTR_W-1:0] lk_attr,
  output logic [CNT_W-1:0]  lock_base,
  output logic [CNT_W-1:0]  lock_victim,
  output logic              op_busy,
  output logic              rd_valid,
  output logic              rd_keep,
  output logic [1:0]        rd_size,
  output logic [31:0]       rd_vaddr,
  output logic [31:0]       rd_paddr,
  output logic [ATTR_W-1:0] rd_attr
);
  xc_op_e           op;
  logic             do_set, do_load, do_fva, do_fall;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx, hit_idx, rd_idx;
  logic             rd_in;

  logic [N_ENTRIES-1:0] ent_valid, ent_keep, ent_match;
  logic [1:0]           ent_size [N_ENTRIES];
  logic [PG_W-1:0]      ent_vp   [N_ENTRIES];
  logic [PG_W-1:0]      ent_pp   [N_ENTRIES];
  logic [ATTR_W-1:0]    ent_attr [N_ENTRIES];
  logic [PG_W-1:0]      hit_mask;

  assign op      = xc_op_e'(op_code);
  assign do_set  = (op == OP_SETLOCK);
  assign do_load = (op == OP_LOAD);
  assign do_fva  = (op == OP_FLUSH_VA);
  assign do_fall = (op == OP_FLUSH_ALL);

  xc_lock_ctrl #(.N(N_ENTRIES), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_lock (
    .clk(clk), .rst(rst), .do_set(do_set), .do_load(do_load),
    .do_flush_all(do_fall), .ld_keep(op_keep),
    .set_base(op_base), .set_victim(op_victim),
    .base_q(lock_base), .victim_q(lock_victim),
    .wr_en(wr_en), .wr_idx(wr_idx), .busy_q(op_busy)
  );

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    xc_entry #(.ATTR_W(ATTR_W)) u_ent (
      .clk(clk), .rst(rst),
      .wr_en(wr_en && (wr_idx == IDX_W'(g))),
      .wr_vpage(op_vpage), .wr_ppage(op_ppage), .wr_size(op_size),
      .wr_keep(op_keep), .wr_attr(op_attr),
      .inv_all(do_fall), .fl_en(do_fva), .fl_page(op_vpage),
      .lk_page(lk_addr[31:12]),
      .valid_q(ent_valid[g]), .keep_q(ent_keep[g]), .size_q(ent_size[g]),
      .vpage_q(ent_vp[g]), .ppage_q(ent_pp[g]), .attr_q(ent_attr[g]),
      .lk_match(ent_match[g])
    );
  end

  xc_prio #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_prio (
    .req(ent_match), .any(lk_hit), .idx(hit_idx)
  );

  assign hit_mask = page_mask(ent_size[hit_idx]);
  assign lk_paddr = lk_hit ? {(ent_pp[hit_idx] & hit_mask) | (lk_addr[31:12] & ~hit_mask),
                              lk_addr[11:0]} : '0;
  assign lk_attr  = lk_hit ? ent_attr[hit_idx] : '0;

  assign rd_in    = (lock_victim < CNT_W'(N_ENTRIES));
  assign rd_idx   = lock_victim[IDX_W-1:0];
  assign rd_valid = rd_in && ent_valid[rd_idx];
  assign rd_keep  = rd_in && ent_keep[rd_idx];
  assign rd_size  = rd_in ? ent_size[rd_idx] : '0;
  assign rd_vaddr = rd_in ? {ent_vp[rd_idx], 12'h000} : '0;
  assign rd_paddr = rd_in ? {ent_pp[rd_idx], 12'h000} : '0;
  assign rd_attr  = rd_in ? ent_attr[rd_idx] : '0;
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk
  import xc_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int CNT_W     = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [2:0]           op_code,
  input logic                 op_keep,
  input logic [CNT_W-1:0]     lock_base,
  input logic [CNT_W-1:0]     lock_victim,
  input logic                 op_busy,
  input logic                 lk_hit,
  input logic [N_ENTRIES-1:0] ent_valid
);
  localparam logic [CNT_W-1:0] N_C = CNT_W'(N_ENTRIES);

  AST_BASE_BOUND: assert property (@(posedge clk) disable iff (rst)
    lock_base <= N_C); // R5
  AST_VICTIM_BOUND: assert property (@(posedge clk) disable iff (rst)
    lock_victim <= N_C); // R5
  AST_FULL_BUSY: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_LOAD && op_keep && lock_base == N_C) |=> (op_busy && $stable(lock_base))); // R4
  AST_KEEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_LOAD && op_keep && lock_base != N_C)
      |=> (lock_base == $past(lock_base) + CNT_W'(1) && lock_victim == lock_base)); // R3
  AST_LOAD_FILLS: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_LOAD && !op_keep && lock_victim < N_C) |=> (ent_valid != '0 && !op_busy)); // R2
  AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_FLUSH_ALL) |=> (lock_base == '0 && lock_victim == '0 && ent_valid == '0)); // R8
  AST_EMPTY_MISS: assert property (@(posedge clk) disable iff (rst)
    (ent_valid == '0) |-> !lk_hit); // R9
endmodule

bind xlat_cache xlat_cache_chk #(.N_ENTRIES(N_ENTRIES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .op_code(op_code), .op_keep(op_keep),
  .lock_base(lock_base), .lock_victim(lock_victim), .op_busy(op_busy),
  .lk_hit(lk_hit), .ent_valid(ent_valid)
);

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb;
  import xc_pkg::*;
  localparam int N  = 8;
  localparam int AW = 4;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [2:0]    op_code = '0;
  logic [19:0]   op_vpage = '0, op_ppage = '0;
  logic [1:0]    op_size = '0;
  logic          op_keep = 1'b0;
  logic [AW-1:0] op_attr = '0;
  logic [CW-1:0] op_base = '0, op_victim = '0;
  logic [31:0]   lk_addr = '0;
  logic          lk_hit, op_busy, rd_valid, rd_keep;
  logic [31:0]   lk_paddr, rd_vaddr, rd_paddr;
  logic [AW-1:0] lk_attr, rd_attr;
  logic [CW-1:0] lock_base, lock_victim;
  logic [1:0]    rd_size;

  xlat_cache #(.N_ENTRIES(N), .ATTR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .op_code(op_code), .op_vpage(op_vpage),
    .op_size(op_size), .op_keep(op_keep), .op_ppage(op_ppage),
    .op_attr(op_attr), .op_base(op_base), .op_victim(op_victim),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
    .lk_attr(lk_attr), .lock_base(lock_base), .lock_victim(lock_victim),
    .op_busy(op_busy), .rd_valid(rd_valid), .rd_keep(rd_keep),
    .rd_size(rd_size), .rd_vaddr(rd_vaddr), .rd_paddr(rd_paddr),
    .rd_attr(rd_attr)
  );

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  bit            m_valid [N];
  bit            m_keep  [N];
  logic [1:0]    m_size  [N];
  logic [19:0]   m_vp    [N];
  logic [19:0]   m_pp    [N];
  logic [AW-1:0] m_attr  [N];
  int            m_base, m_victim;
  bit            m_busy;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic m_write(input int i);
    m_valid[i] = 1'b1;
    m_keep[i]  = op_keep;
    m_size[i]  = op_size;
    m_vp[i]    = op_vpage & page_mask(op_size);
    m_pp[i]    = op_ppage & page_mask(op_size);
    m_attr[i]  = op_attr;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_base = 0; m_victim = 0; m_busy = 1'b0;
      for (int i = 0; i < N; i++) begin
        m_valid[i] = 1'b0; m_keep[i] = 1'b0; m_size[i] = '0;
        m_vp[i] = '0; m_pp[i] = '0; m_attr[i] = '0;
      end
    end else begin
      m_busy = 1'b0;
      case (op_code)
        3'd1: begin
          m_base   = (int'(op_base) > N) ? N : int'(op_base);
          m_victim = (int'(op_victim) > N) ? N : int'(op_victim);
        end
        3'd2: begin
          if (op_keep) begin
            if (m_base == N) m_busy = 1'b1;
            else begin m_write(m_base); m_base++; m_victim = m_base; end
          end else begin
            if (m_victim >= N) m_busy = 1'b1;
            else begin
              m_write(m_victim); m_victim++;
              if (m_victim == N) m_victim = m_base;
            end
          end
        end
        3'd3: begin
          for (int i = 0; i < N; i++)
            if (m_valid[i] && (((op_vpage ^ m_vp[i]) & page_mask(m_size[i])) == '0))
              m_valid[i] = 1'b0;
        end
        3'd4: begin
          m_base = 0; m_victim = 0;
          for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
        end
        default: ;
      endcase
    end
  end

  // compare against the model after every edge
  always @(posedge clk) begin
    #3;
    if (!rst) begin
      int hi;
      logic [19:0] mk;
      hi = -1;
      for (int i = N - 1; i >= 0; i--)
        if (m_valid[i] && (((lk_addr[31:12] ^ m_vp[i]) & page_mask(m_size[i])) == '0)) hi = i;
      chk("R3 lock_base", 32'(lock_base), 32'(m_base));
      chk("R2 lock_victim", 32'(lock_victim), 32'(m_victim));
      chk("R4 op_busy", 32'(op_busy), 32'(m_busy));
      chk("R9 lk_hit", 32'(lk_hit), 32'(hi >= 0));
      if (hi >= 0) begin
        mk = page_mask(m_size[hi]);
        chk("R9 lk_paddr", lk_paddr, {(m_pp[hi] & mk) | (lk_addr[31:12] & ~mk), lk_addr[11:0]});
        chk("R9 lk_attr", 32'(lk_attr), 32'(m_attr[hi]));
      end
      if (m_victim < N) begin
        chk("R6 rd_valid", 32'(rd_valid), 32'(m_valid[m_victim]));
        chk("R6 rd_keep", 32'(rd_keep), 32'(m_keep[m_victim]));
        chk("R6 rd_size", 32'(rd_size), 32'(m_size[m_victim]));
        chk("R6 rd_vaddr", rd_vaddr, {m_vp[m_victim], 12'h000});
        chk("R6 rd_paddr", rd_paddr, {m_pp[m_victim], 12'h000});
        chk("R6 rd_attr", 32'(rd_attr), 32'(m_attr[m_victim]));
      end else begin
        chk("R6 rd_valid out of range", 32'(rd_valid), 32'd0);
      end
    end
  end

  task automatic do_op(input logic [2:0] c, input logic [19:0] vp, input logic [1:0] sz,
                       input logic kp, input logic [19:0] pp, input logic [AW-1:0] at,
                       input logic [CW-1:0] b, input logic [CW-1:0] v);
    op_code = c; op_vpage = vp; op_size = sz; op_keep = kp;
    op_ppage = pp; op_attr = at; op_base = b; op_victim = v;
    @(negedge clk);
    op_code = OP_NOP;
  endtask

  task automatic look(input logic [31:0] a);
    lk_addr = a;
    #1;
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 base after reset", 32'(lock_base), 32'd0);
    chk("R1 victim after reset", 32'(lock_victim), 32'd0);
    chk("R1 no hit after reset", 32'(lk_hit), 32'd0);

    // two overlapping slots: 1 MB at 0, 4 KB at 1
    do_op(OP_LOAD, 20'h00100, 2'd1, 1'b0, 20'h80000, 4'h1, '0, '0);
    do_op(OP_LOAD, 20'h00103, 2'd3, 1'b0, 20'h90000, 4'h2, '0, '0);
    look(32'h0010_3456);
    chk("R10 lowest index wins", lk_paddr, 32'h8000_3456);
    chk("R11 hit without clock", 32'(lk_hit), 32'd1);
    look(32'h0020_0000);
    chk("R11 miss without clock", 32'(lk_hit), 32'd0);

    // size handling
    do_op(OP_LOAD, 20'h20000, 2'd0, 1'b0, 20'h40000, 4'h3, '0, '0);
    do_op(OP_LOAD, 20'h30010, 2'd2, 1'b0, 20'h50020, 4'h4, '0, '0);
    look(32'h20AB_CDEF);
    chk("R9 16MB translate", lk_paddr, 32'h40AB_CDEF);
    look(32'h3001_1234);
    chk("R9 64KB translate", lk_paddr, 32'h5002_1234);
    chk("R9 64KB attr", 32'(lk_attr), 32'h4);
    look(32'h3002_0000);
    chk("R9 64KB out of range", 32'(lk_hit), 32'd0);

    // flush by address
    do_op(OP_FLUSH_VA, 20'h00103, '0, 1'b0, '0, '0, '0, '0);
    look(32'h0010_3456);
    chk("R7 covered slots gone", 32'(lk_hit), 32'd0);
    look(32'h20AB_CDEF);
    chk("R7 other slot kept", 32'(lk_hit), 32'd1);
    do_op(OP_SETLOCK, '0, '0, 1'b0, '0, '0, 4'd0, 4'd1);
    chk("R7 readback flushed slot", 32'(rd_valid), 32'd0);
    do_op(OP_SETLOCK, '0, '0, 1'b0, '0, '0, 4'd0, 4'd2);
    chk("R6 readback valid", 32'(rd_valid), 32'd1);
    chk("R6 readback paddr", rd_paddr, 32'h4000_0000);

    // global flush
    do_op(OP_FLUSH_ALL, '0, '0, 1'b0, '0, '0, '0, '0);
    chk("R8 base zero", 32'(lock_base), 32'd0);
    chk("R8 victim zero", 32'(lock_victim), 32'd0);
    chk("R8 no hit", 32'(lk_hit), 32'd0);

    // fill with preserved loads, then overflow
    for (int i = 0; i < N; i++)
      do_op(OP_LOAD, 20'h60000 + 20'(i), 2'd3, 1'b1, 20'h70000 + 20'(i), 4'(i), '0, '0);
    chk("R3 base full", 32'(lock_base), 32'(N));
    chk("R3 victim follows base", 32'(lock_victim), 32'(N));
    do_op(OP_LOAD, 20'h61000, 2'd3, 1'b1, 20'h71000, 4'h0, '0, '0);
    chk("R4 busy on full preserve", 32'(op_busy), 32'd1);
    chk("R4 base held", 32'(lock_base), 32'(N));
    do_op(OP_LOAD, 20'h61000, 2'd3, 1'b0, 20'h71000, 4'h0, '0, '0);
    chk("R4 busy on victim at end", 32'(op_busy), 32'd1);
    look(32'h6100_0000);
    chk("R4 rejected load not stored", 32'(lk_hit), 32'd0);

    // victim wraps to base
    do_op(OP_SETLOCK, '0, '0, 1'b0, '0, '0, 4'd3, 4'd7);
    do_op(OP_LOAD, 20'h62000, 2'd3, 1'b0, 20'h72000, 4'h5, '0, '0);
    chk("R2 wrap to base", 32'(lock_victim), 32'd3);
    chk("R4 busy clears", 32'(op_busy), 32'd0);
    do_op(OP_SETLOCK, '0, '0, 1'b0, '0, '0, 4'd12, 4'd15);
    chk("R5 base saturates", 32'(lock_base), 32'(N));
    chk("R5 victim saturates", 32'(lock_victim), 32'(N));

    // mixed traffic against the model
    do_op(OP_FLUSH_ALL, '0, '0, 1'b0, '0, '0, '0, '0);
    for (int k = 0; k < 600; k++) begin
      int sel;
      logic [19:0] va;
      sel = $urandom % 20;
      va = 20'h10000 | 20'(($urandom % 4) << 8) | 20'(($urandom % 4) << 4) | 20'($urandom % 4);
      lk_addr = {20'h10000 | 20'(($urandom % 4) << 8) | 20'(($urandom % 4) << 4) | 20'($urandom % 4),
                 12'($urandom)};
      if (sel < 8)
        do_op(OP_LOAD, va, 2'($urandom), 1'b0, 20'($urandom), 4'($urandom), '0, '0);
      else if (sel < 11)
        do_op(OP_LOAD, va, 2'($urandom), 1'b1, 20'($urandom), 4'($urandom), '0, '0);
      else if (sel < 14)
        do_op(OP_FLUSH_VA, va, '0, 1'b0, '0, '0, '0, '0);
      else if (sel < 17)
        do_op(OP_SETLOCK, '0, '0, 1'b0, '0, '0, 4'($urandom % 11), 4'($urandom % 11));
      else if (sel == 17 && ($urandom % 4) == 0)
        do_op(OP_FLUSH_ALL, '0, '0, 1'b0, '0, '0, '0, '0);
      else
        do_op(OP_NOP, '0, '0, 1'b0, '0, '0, '0, '0);
    end
    @(negedge clk);
    finish_run();
  end
endmodule